// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides which of eight interrupt request lines, if any, is offered to the processor. It receives the controller's request, mask and in-service registers as plain vectors, together with a rotation offset and three mode flags. The block is purely combinational. Its outputs follow its inputs within the same cycle, and its valid output drives the controller's interrupt line directly.

Priority is set by position, and position 0 ranks highest. A rotation offset links positions to physical lines: position p belongs to line (p + offset) mod 8. Changing the offset moves the lowest-ranked slot around the ring. A pending request wins only when it ranks strictly above every in-service level that still counts. Two modes change which in-service bits count. Special mask mode drops in-service lines that are currently masked. Fully nested mode, on the cascade master, drops the cascade line so that a slave can be re-entered.

Top module: `irq_prio_resolver`

## Requirements
- R1: A request line whose mask bit is 1 is never presented. The eligible set is the request vector ANDed with the inverted mask vector.
- R2: When the eligible set is empty, `int_valid` is 0.
- R3: Priority position 0 is the highest, and position p corresponds to line (p + `rot_off`) mod 8. Among eligible lines, the one at the smallest position is the candidate.
- R4: When no in-service bit counts and the eligible set is non-empty, `int_valid` is 1.
- R5: The candidate is presented only if its position is strictly smaller than the smallest position of any counted in-service bit. An equal position blocks it, and so does a smaller one.
- R6: With `spec_mask_en` = 1, in-service bits whose mask bit is 1 are not counted. With `spec_mask_en` = 0, every in-service bit is counted.
- R7: With `nest_en` = 1 and `is_master` = 1, in-service bit 2 (the cascade line) is not counted. With either flag at 0, that bit is counted.
- R8: `int_line` equals (winning position + `rot_off`) mod 8 when `int_valid` is 1, and 0 when `int_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_bits | input | 8 | Pending request vector, bit i = line i |
| mask_bits | input | 8 | Mask vector, 1 = line masked |
| svc_bits | input | 8 | In-service vector, 1 = line being serviced |
| rot_off | input | 3 | Rotation offset: line number at priority position 0 |
| spec_mask_en | input | 1 | Special mask mode: ignore masked in-service bits |
| nest_en | input | 1 | Fully nested mode for cascaded operation |
| is_master | input | 1 | 1 when this controller is the cascade master |
| int_valid | output | 1 | A request is presented (interrupt line) |
| int_line | output | 3 | Line number of the presented request, 0 when none |

## Verification
The bench builds the block with its default eight lines and the cascade tap on line 2. At this size, the bench steps through all eight rotation offsets and all eight combinations of the three mode flags. Under each of these 64 settings it applies 256 pseudo-random sets of request, mask and in-service values. Around this sweep, directed vectors cover the boundaries an arbitrary draw rarely hits:
- an in-service level equal to the candidate's position
- wrap-around of the rotation
- a masked in-service bit with and without special mask mode
- the cascade bit seen from master and from slave

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    // Default geometry of the resolver; NUM_LINES must be a power of two.
    localparam int unsigned DFLT_LINES   = 8;
    localparam int unsigned DFLT_CASCADE = 2;
endpackage

// File: rtl/irq_prio_rotate.sv
// Reorders a line vector into priority-position order: out[p] = in[(p + off) mod N].
module irq_prio_rotate #(
    parameter int unsigned N = irq_prio_pkg::DFLT_LINES,
    localparam int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] vec_in,
    input  logic [W-1:0] off,
    output logic [N-1:0] vec_out
);
    for (genvar p = 0; p < N; p++) begin : g_pos
        logic [W-1:0] src;
        assign src        = W'(p) + off;
        assign vec_out[p] = vec_in[src];
    end
endmodule

// File: rtl/irq_prio_search.sv
// Returns the smallest set position of a vector, or N when the vector is empty.
module irq_prio_search #(
    parameter int unsigned N = irq_prio_pkg::DFLT_LINES,
    localparam int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic [W:0]   pos
);
    always_comb begin
        pos = (W+1)'(N);
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                pos = (W+1)'(i);
            end
        end
    end
endmodule

// File: rtl/irq_prio_level_filter.sv
// Selects which in-service bits take part in the current-level search.
module irq_prio_level_filter #(
    parameter int unsigned N       = irq_prio_pkg::DFLT_LINES,
    parameter int unsigned CASCADE = irq_prio_pkg::DFLT_CASCADE
) (
    input  logic [N-1:0] svc_bits,
    input  logic [N-1:0] mask_bits,
    input  logic         spec_mask_en,
    input  logic         nest_en,
    input  logic         is_master,
    output logic [N-1:0] svc_eff
);
    logic [N-1:0] after_mask;
    logic [N-1:0] cascade_drop;

    assign after_mask = spec_mask_en ? (svc_bits & ~mask_bits) : svc_bits;

    for (genvar i = 0; i < N; i++) begin : g_drop
        if (i == CASCADE) begin : g_tap
            assign cascade_drop[i] = nest_en & is_master;
        end else begin : g_plain
            assign cascade_drop[i] = 1'b0;
        end
    end

    assign svc_eff = after_mask & ~cascade_drop;

    // R7: the cascade bit never survives the filter in master nested mode
    always_comb begin
        if (nest_en && is_master) begin
            p_cascade_dropped_r7: assert (!svc_eff[CASCADE]);
        end
    end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
    parameter int unsigned NUM_LINES    = irq_prio_pkg::DFLT_LINES,
    parameter int unsigned CASCADE_LINE = irq_prio_pkg::DFLT_CASCADE,
    localparam int unsigned W = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] req_bits,
    input  logic [NUM_LINES-1:0] mask_bits,
    input  logic [NUM_LINES-1:0] svc_bits,
    input  logic [W-1:0]         rot_off,
    input  logic                 spec_mask_en,
    input  logic                 nest_en,
    input  logic                 is_master,
    output logic                 int_valid,
    output logic [W-1:0]         int_line
);
    logic [NUM_LINES-1:0] eligible;
    logic [NUM_LINES-1:0] svc_eff;
    logic [NUM_LINES-1:0] elig_rot;
    logic [NUM_LINES-1:0] svc_rot;
    logic [W:0]           win_pos;
    logic [W:0]           cur_pos;

    assign eligible = req_bits & ~mask_bits;

    irq_prio_level_filter #(.N(NUM_LINES), .CASCADE(CASCADE_LINE)) u_filter (
        .svc_bits     (svc_bits),
        .mask_bits    (mask_bits),
        .spec_mask_en (spec_mask_en),
        .nest_en      (nest_en),
        .is_master    (is_master),
        .svc_eff      (svc_eff)
    );

    irq_prio_rotate #(.N(NUM_LINES)) u_rot_req (
        .vec_in  (eligible),
        .off     (rot_off),
        .vec_out (elig_rot)
    );

    irq_prio_rotate #(.N(NUM_LINES)) u_rot_svc (
        .vec_in  (svc_eff),
        .off     (rot_off),
        .vec_out (svc_rot)
    );

    irq_prio_search #(.N(NUM_LINES)) u_find_req (
        .vec (elig_rot),
        .pos (win_pos)
    );

    irq_prio_search #(.N(NUM_LINES)) u_find_svc (
        .vec (svc_rot),
        .pos (cur_pos)
    );

    // The sentinel N is never smaller than anything, so an empty eligible set never wins.
    always_comb begin
        int_valid = (win_pos < cur_pos);
        int_line  = int_valid ? (win_pos[W-1:0] + rot_off) : '0;
    end

    always_comb begin
        if (int_valid) begin
            p_win_unmasked_r1: assert (req_bits[int_line] && !mask_bits[int_line]);
        end
        if (eligible == '0) begin
            p_quiet_when_none_r2: assert (!int_valid);
        end
        if (svc_eff == '0 && eligible != '0) begin
            p_idle_accepts_r4: assert (int_valid);
        end
        if (int_valid) begin
            p_not_in_service_r5: assert (!svc_eff[int_line]);
        end
        if (spec_mask_en && (svc_bits & ~mask_bits) == '0 && !(nest_en && is_master) && eligible != '0) begin
            p_masked_svc_ignored_r6: assert (int_valid);
        end
        if (!int_valid) begin
            p_line_zero_idle_r8: assert (int_line == '0);
        end
    end
endmodule

// File: tb/irq_prio_resolver_bench.sv
module irq_prio_resolver_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [7:0] req_bits, mask_bits, svc_bits;
    logic [2:0] rot_off;
    logic spec_mask_en, nest_en, is_master;
    logic int_valid;
    logic [2:0] int_line;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic [31:0] lfsr = 32'hACE1_2357;

    irq_prio_resolver u_irq_prio_resolver (
        .req_bits(req_bits), .mask_bits(mask_bits), .svc_bits(svc_bits),
        .rot_off(rot_off), .spec_mask_en(spec_mask_en), .nest_en(nest_en),
        .is_master(is_master), .int_valid(int_valid), .int_line(int_line)
    );

    function automatic int first_pos(logic [7:0] v, logic [2:0] off);
        for (int p = 0; p < 8; p++) begin
            if (v[(p + off) % 8]) return p;
        end
        return 8;
    endfunction

    function automatic logic [3:0] model(logic [7:0] rq, logic [7:0] mk, logic [7:0] sv,
                                         logic [2:0] off, logic sm, logic ne, logic ms);
        logic [7:0] s;
        int cp, sp;
        cp = first_pos(rq & ~mk, off);
        s  = sv;
        if (sm) s = s & ~mk;
        if (ne && ms) s[2] = 1'b0;
        sp = first_pos(s, off);
        if (cp < 8 && cp < sp) return {1'b1, 3'((cp + off) % 8)};
        return 4'b0000;
    endfunction

    task automatic apply(input logic [7:0] rq, input logic [7:0] mk, input logic [7:0] sv,
                         input logic [2:0] off, input logic sm, input logic ne, input logic ms,
                         input string tag);
        logic [3:0] exp;
        @(posedge clk);
        req_bits = rq; mask_bits = mk; svc_bits = sv; rot_off = off;
        spec_mask_en = sm; nest_en = ne; is_master = ms;
        exp = model(rq, mk, sv, off, sm, ne, ms);
        @(negedge clk);
        checks++;
        if ({int_valid, int_line} !== exp) begin
            errors++;
            $display("FAIL %s: req=%h mask=%h svc=%h off=%0d modes=%b%b%b got valid=%b line=%0d expected valid=%b line=%0d",
                     tag, rq, mk, sv, off, sm, ne, ms, int_valid, int_line, exp[3], exp[2:0]);
        end
    endtask

    function automatic logic [31:0] step(logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    initial begin
        req_bits = '0; mask_bits = '0; svc_bits = '0; rot_off = '0;
        spec_mask_en = 0; nest_en = 0; is_master = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset-time state: nothing pending, nothing presented (R2, R8)
        apply(8'h00, 8'h00, 8'h00, 3'd0, 0, 0, 0, "R2 idle");
        apply(8'h01, 8'h01, 8'h00, 3'd0, 0, 0, 0, "R1 masked only");
        apply(8'h03, 8'h01, 8'h00, 3'd0, 0, 0, 0, "R1 next unmasked");
        apply(8'h81, 8'h00, 8'h00, 3'd0, 0, 0, 0, "R3 offset0");
        apply(8'h81, 8'h00, 8'h00, 3'd1, 0, 0, 0, "R3 wrap offset1");
        apply(8'h80, 8'h00, 8'h00, 3'd0, 0, 0, 0, "R4 empty service");
        apply(8'h04, 8'h00, 8'h04, 3'd0, 0, 0, 0, "R5 equal blocks");
        apply(8'h02, 8'h00, 8'h04, 3'd0, 0, 0, 0, "R5 higher wins");
        apply(8'h08, 8'h00, 8'h04, 3'd0, 0, 0, 0, "R5 lower blocked");
        apply(8'h02, 8'h01, 8'h01, 3'd0, 1, 0, 0, "R6 special mask on");
        apply(8'h02, 8'h01, 8'h01, 3'd0, 0, 0, 0, "R6 special mask off");
        apply(8'h08, 8'h00, 8'h04, 3'd0, 0, 1, 1, "R7 master nested");
        apply(8'h04, 8'h00, 8'h04, 3'd0, 0, 1, 1, "R7 cascade reentry");
        apply(8'h08, 8'h00, 8'h04, 3'd0, 0, 1, 0, "R7 slave counts bit2");
        apply(8'h10, 8'h00, 8'h00, 3'd6, 0, 0, 0, "R8 line number");
        apply(8'h30, 8'h00, 8'h00, 3'd5, 0, 0, 0, "R8 rotated winner");
        for (int off = 0; off < 8; off++) begin
            for (int md = 0; md < 8; md++) begin
                for (int k = 0; k < 256; k++) begin
                    lfsr = step(step(step(lfsr)));
                    apply(lfsr[7:0], lfsr[15:8] & lfsr[23:16], lfsr[31:24] & lfsr[11:4],
                          3'(off), md[0], md[1], md[2], "sweep R3 R5 R6 R7 R8");
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: run did not complete, got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule